// File: doc/BRIEF.md
# Lockable Watchdog with Pre-timeout

This block is a watchdog timer behind five 16-bit registers. It counts down in half-second units, driven by a slow strobe input. Firmware must prove that it is alive by writing a two-word key sequence to a service register. If that sequence is missing when the count runs out, the block pulses a reset-request output and records the cause. The same output can be pulsed on purpose through a software-reset bit.

An early-warning interrupt is raised a programmable number of units before expiry, so that software can log state before the reset hits. Several control fields can be set only once after reset, so a runaway program cannot disarm the timer:
- the enable bit and the reset-on-timeout bit can only ever be set;
- the suspend, debug and wait-disable bits freeze after the first control write;
- the interrupt enable and the warning interval freeze after the first interrupt-control write.

The bus side is a single-cycle write strobe with a byte address. Read data is combinational from the address.

Top module: `lwd_top`

## Requirements
- R1: After reset: control reads 0x0000, reset-status reads 0x0000, interrupt-control reads 0x0004, misc reads 0x0001, and `irq` and `rst_req` are low.
- R2: Registers sit at byte offsets control 0x0, service 0x2, reset-status 0x4, interrupt-control 0x6 and misc 0x8. Address bit 0 is ignored. Offsets 0xA and above read 0x0000 and ignore writes. The service register always reads 0x0000.
- R3: Control layout:
  - bits 15:8 hold the timeout value;
  - bit 5 is a plain read/write bit;
  - bit 4 (software reset) and bit 6 read 0;
  - bits 0 (suspend), 1 (debug) and 7 (wait-disable) take their value from the first control write after reset only.
- R4: Control bit 2 (enable) and bit 3 (reset on timeout) can be set but never cleared by a write; only reset clears them.
- R5: When enable first becomes 1, the count is loaded with timeout+1 on the next clock. Each `tick` while enabled lowers it by one. A tick that finds a count of 1 is an expiry and reloads timeout+1. An expiry with bit 3 set gives a one-cycle `rst_req` pulse one clock later and sets reset-status to 0x0002.
- R6: Writing 0x5555 and then 0xAAAA to the service register reloads the count with timeout+1. Any other written value restarts the matching. A repeated 0x5555 keeps the checker waiting for 0xAAAA.
- R7: If a sequence-completing service write and an expiring tick fall in the same cycle, the reload wins and no reset pulse is produced.
- R8: Writing control with bit 4 = 1 gives a one-cycle `rst_req` pulse and sets reset-status to 0x0001. If a timeout reset lands in the same cycle, reset-status shows 0x0002.
- R9: Interrupt-control layout:
  - bit 15 is the interrupt enable and bits 7:0 the warning interval; both freeze after the first write to this register;
  - bit 14 is the status; it sets when a non-expiring tick leaves a count equal to the interval while the enable is 1;
  - writing 1 to bit 14 clears the status, but a set in the same cycle wins.
- R10: `irq` equals status AND interrupt enable.
- R11: Misc bit 0 (power-down enable) is a plain read/write bit with reset value 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per half-second unit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Pre-timeout interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Two functions can meet in the same clock edge:
- the service checker's reload and the counter's expiry;
- a software reset request and a timeout reset.

The bench brings the count down to 1 and arms the key checker with 0x5555. It then drives the strobe and the 0xAAAA write in one cycle. It judges the result by the absence of a pulse and by the full timeout+1 ticks needed before the next expiry. Random ticks, keys and stray values are compared against a bench model of the count and key state, which also catches an expiry coinciding with a pending key.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
   localparam logic [2:0] IDX_CTRL = 3'd0;
   localparam logic [2:0] IDX_SVC  = 3'd1;
   localparam logic [2:0] IDX_STAT = 3'd2;
   localparam logic [2:0] IDX_INTC = 3'd3;
   localparam logic [2:0] IDX_MISC = 3'd4;

   localparam logic [15:0] KEY_FIRST  = 16'h5555;
   localparam logic [15:0] KEY_SECOND = 16'hAAAA;

   localparam int B_SUSP = 0;
   localparam int B_DBG  = 1;
   localparam int B_EN   = 2;
   localparam int B_TOE  = 3;
   localparam int B_SWR  = 4;
   localparam int B_ASRT = 5;
   localparam int B_WAIT = 7;

   localparam int B_IEN  = 15;
   localparam int B_ISTS = 14;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'b00,
      CAUSE_SW   = 2'b01,
      CAUSE_TMO  = 2'b10
   } cause_t;
endpackage

// File: rtl/lwd_ctrl.sv
module lwd_ctrl #(
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [15:0]      wdata,
   output logic [TMO_W-1:0] wt,
   output logic             en,
   output logic             toe,
   output logic             sw_req,
   output logic             misc_lock,
   output logic [2:0]       misc_bits,
   output logic [15:0]      rd
);
   import lwd_pkg::*;

   logic asrt_q;
   logic unused_bits;
   assign unused_bits = ^{wdata[6], wdata[15:8]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wt        <= '0;
         en        <= 1'b0;
         toe       <= 1'b0;
         asrt_q    <= 1'b0;
         misc_lock <= 1'b0;
         misc_bits <= '0;
      end else if (wr) begin
         wt     <= wdata[8 +: TMO_W];
         asrt_q <= wdata[B_ASRT];
         en     <= en  | wdata[B_EN];
         toe    <= toe | wdata[B_TOE];
         if (!misc_lock) begin
            misc_bits <= {wdata[B_WAIT], wdata[B_DBG], wdata[B_SUSP]};
            misc_lock <= 1'b1;
         end
      end
   end

   assign sw_req = wr & wdata[B_SWR];

   always_comb begin
      rd          = '0;
      rd[8 +: TMO_W] = wt;
      rd[B_WAIT]  = misc_bits[2];
      rd[B_ASRT]  = asrt_q;
      rd[B_TOE]   = toe;
      rd[B_EN]    = en;
      rd[B_DBG]   = misc_bits[1];
      rd[B_SUSP]  = misc_bits[0];
   end
endmodule

// File: rtl/lwd_svc.sv
module lwd_svc (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [15:0] wdata,
   output logic        done
);
   import lwd_pkg::*;

   logic armed;

   assign done = wr && armed && (wdata == KEY_SECOND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  armed <= 1'b0;
      else if (wr) armed <= (wdata == KEY_FIRST);
   end
endmodule

// File: rtl/lwd_cnt.sv
module lwd_cnt #(
   parameter int TMO_W = 8,
   parameter int PRE_W = 8,
   localparam int CNT_W = TMO_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             reload,
   input  logic [TMO_W-1:0] wt,
   input  logic [PRE_W-1:0] pre,
   input  logic             wie,
   input  logic             sts_clr,
   output logic             expire,
   output logic             sts,
   output logic [CNT_W-1:0] cnt
);
   logic             en_d;
   logic             start;
   logic             pre_hit;
   logic [CNT_W-1:0] full;
   logic [CNT_W-1:0] nxt;

   assign full    = CNT_W'(wt) + CNT_W'(1);
   assign nxt     = cnt - CNT_W'(1);
   assign start   = en && !en_d;
   assign expire  = en && !start && !reload && tick && (cnt == CNT_W'(1));
   assign pre_hit = en && !start && !reload && tick && !expire && wie
                    && (nxt == CNT_W'(pre));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d <= 1'b0;
         cnt  <= '0;
      end else begin
         en_d <= en;
         if (start || (en && reload) || expire) cnt <= full;
         else if (en && tick)                   cnt <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sts <= 1'b0;
      else if (pre_hit) sts <= 1'b1;
      else if (sts_clr) sts <= 1'b0;
   end
endmodule

// File: rtl/lwd_top.sv
module lwd_top #(
   parameter int TMO_W = 8,
   parameter int PRE_W = 8,
   parameter logic [7:0] PRE_RST = 8'h04
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        bus_wr,
   input  logic [3:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        irq,
   output logic        rst_req
);
   import lwd_pkg::*;
   localparam int CNT_W = TMO_W + 1;

   if (TMO_W < 1 || TMO_W > 8) begin : g_bad_tmo
      $error("TMO_W must lie in 1..8");
   end
   if (PRE_W < 1 || PRE_W > TMO_W) begin : g_bad_pre
      $error("PRE_W must lie in 1..TMO_W");
   end

   logic             in_range;
   logic [2:0]       idx;
   logic             wr_ctrl, wr_svc, wr_intc, wr_misc;
   logic [TMO_W-1:0] wt;
   logic             en, toe, sw_req, misc_lock;
   logic [2:0]       misc_bits;
   logic [15:0]      ctrl_rd;
   logic             svc_done, expire, sts;
   logic [CNT_W-1:0] cnt;
   logic             wie, wicr_lock, pde;
   logic [PRE_W-1:0] pre;
   cause_t           cause;
   logic [15:0]      intc_rd;

   assign idx      = bus_addr[3:1];
   assign in_range = (idx <= IDX_MISC);
   assign wr_ctrl  = bus_wr && in_range && (idx == IDX_CTRL);
   assign wr_svc   = bus_wr && in_range && (idx == IDX_SVC);
   assign wr_intc  = bus_wr && in_range && (idx == IDX_INTC);
   assign wr_misc  = bus_wr && in_range && (idx == IDX_MISC);

   lwd_ctrl #(.TMO_W(TMO_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(bus_wdata),
      .wt(wt), .en(en), .toe(toe), .sw_req(sw_req),
      .misc_lock(misc_lock), .misc_bits(misc_bits), .rd(ctrl_rd));

   lwd_svc u_svc (
      .clk(clk), .rst_n(rst_n), .wr(wr_svc), .wdata(bus_wdata),
      .done(svc_done));

   lwd_cnt #(.TMO_W(TMO_W), .PRE_W(PRE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .reload(svc_done),
      .wt(wt), .pre(pre), .wie(wie), .sts_clr(wr_intc && bus_wdata[B_ISTS]),
      .expire(expire), .sts(sts), .cnt(cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wie       <= 1'b0;
         pre       <= PRE_W'(PRE_RST);
         wicr_lock <= 1'b0;
         pde       <= 1'b1;
      end else begin
         if (wr_intc && !wicr_lock) begin
            wie       <= bus_wdata[B_IEN];
            pre       <= bus_wdata[PRE_W-1:0];
            wicr_lock <= 1'b1;
         end
         if (wr_misc) pde <= bus_wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
         cause   <= CAUSE_NONE;
      end else begin
         rst_req <= (expire && toe) || sw_req;
         if (expire && toe) cause <= CAUSE_TMO;
         else if (sw_req)   cause <= CAUSE_SW;
      end
   end

   assign irq = sts && wie;

   always_comb begin
      intc_rd               = '0;
      intc_rd[B_IEN]        = wie;
      intc_rd[B_ISTS]       = sts;
      intc_rd[PRE_W-1:0]    = pre;
   end

   always_comb begin
      bus_rdata = '0;
      if (in_range) begin
         case (idx)
            IDX_CTRL: bus_rdata = ctrl_rd;
            IDX_STAT: bus_rdata = {14'b0, cause};
            IDX_INTC: bus_rdata = intc_rd;
            IDX_MISC: bus_rdata = {15'b0, pde};
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/lwd_chk.sv
module lwd_chk #(
   parameter int TMO_W = 8,
   parameter int PRE_W = 8,
   localparam int CNT_W = TMO_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             toe,
   input logic             misc_lock,
   input logic [2:0]       misc_bits,
   input logic             svc_done,
   input logic [CNT_W-1:0] cnt,
   input logic [TMO_W-1:0] wt,
   input logic             irq,
   input logic             wie,
   input logic             wicr_lock,
   input logic [PRE_W-1:0] pre,
   input logic             expire,
   input logic             rst_req
);
   AST_ENA_HELD: assert property (@(posedge clk) disable iff (!rst_n) en |=> en); // R4
   AST_TOE_HELD: assert property (@(posedge clk) disable iff (!rst_n) toe |=> toe); // R4
   AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n) misc_lock |=> $stable(misc_bits)); // R3
   AST_SVC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) (en && svc_done) |=> (cnt == CNT_W'($past(wt)) + CNT_W'(1))); // R6
   AST_NO_EXPIRE_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) svc_done |-> !expire); // R7
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> wie); // R10
   AST_WICR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) wicr_lock |=> ($stable(pre) && $stable(wie))); // R9
   AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (expire && toe) |=> rst_req); // R5
endmodule

bind lwd_top lwd_chk #(.TMO_W(TMO_W), .PRE_W(PRE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .toe(toe), .misc_lock(misc_lock),
   .misc_bits(misc_bits), .svc_done(svc_done), .cnt(cnt), .wt(wt),
   .irq(irq), .wie(wie), .wicr_lock(wicr_lock), .pre(pre),
   .expire(expire), .rst_req(rst_req));

// File: tb/lwd_top_test.sv
module lwd_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq, rst_req;

   int checks = 0;
   int errs = 0;

   // bench model state
   int m_cnt = 0, m_wt = 0, m_pre = 4;
   bit m_arm = 0, m_en = 0, m_load = 0, m_toe = 0, m_sts = 0, m_wie = 0, m_wlock = 0;

   always #10 clk = ~clk;

   lwd_top uut (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .rst_req(rst_req));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, input int exp, input string tag);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   function automatic bit model(input bit tk, input bit wr, input logic [3:0] a, input logic [15:0] d);
      bit en_before = m_en;
      bit done = 0, swr = 0, clr = 0, set = 0, r = 0;
      if (wr && a[3:1] == 3'd1) begin
         done  = (d == 16'hAAAA) && m_arm;
         m_arm = (d == 16'h5555);
      end
      if (wr && a[3:1] == 3'd0) begin
         m_wt  = d[15:8];
         m_toe = m_toe | d[3];
         swr   = d[4];
         if (d[2] && !m_en) begin m_en = 1; m_load = 1; end
      end
      if (wr && a[3:1] == 3'd3) begin
         if (!m_wlock) begin m_wie = d[15]; m_pre = d[7:0]; m_wlock = 1; end
         clr = d[14];
      end
      if (en_before) begin
         if (m_load) begin m_cnt = m_wt + 1; m_load = 0; end
         else if (done) m_cnt = m_wt + 1;
         else if (tk) begin
            if (m_cnt == 1) begin r = m_toe; m_cnt = m_wt + 1; end
            else begin
               m_cnt--;
               if (m_wie && m_cnt == m_pre) set = 1;
            end
         end
      end
      if (set) m_sts = 1;
      else if (clr) m_sts = 0;
      return r | swr;
   endfunction

   // one clock cycle of stimulus, then compare outputs with the model
   task automatic op(input bit tk, input bit wr, input logic [3:0] a, input logic [15:0] d, input string tag);
      bit exp_rst;
      exp_rst = model(tk, wr, a, d);
      tick = tk; bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      chk({tag, " rst_req"}, rst_req, exp_rst);
      chk({tag, " irq (R10)"}, irq, m_sts & m_wie);
      tick = 0; bus_wr = 0;
   endtask

   initial begin
      #(20 * 200000);
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd7;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      rd(4'h0, 16'h0000, "R1 ctrl");
      rd(4'h4, 16'h0000, "R1 status");
      rd(4'h6, 16'h0004, "R1 intc");
      rd(4'h8, 16'h0001, "R1 misc");
      chk("R1 irq", irq, 0);
      chk("R1 rst_req", rst_req, 0);
      // R2 map
      rd(4'h2, 16'h0000, "R2 service reads 0");
      rd(4'hC, 16'h0000, "R2 out of range");
      // R3/R4 control and locks
      op(0, 1, 4'h0, 16'h038F, "R4 enable");
      rd(4'h0, 16'h038F, "R3 ctrl readback");
      op(0, 0, 4'h0, 16'h0000, "R5 load cycle");
      op(0, 1, 4'h0, 16'h0300, "R4 clear attempt");
      rd(4'h0, 16'h038F, "R4 R3 locked bits");
      rd(4'h1, 16'h038F, "R2 addr bit0 ignored");
      op(0, 1, 4'hC, 16'hFFFF, "R2 stray write");
      rd(4'h0, 16'h038F, "R2 stray write no effect");
      rd(4'hC, 16'h0000, "R2 stray read");
      op(0, 1, 4'h0, 16'h0320, "R3 bit5");
      rd(4'h0, 16'h03AF, "R3 bit5 free");
      op(0, 1, 4'h0, 16'h0300, "R3 bit5 clr");
      rd(4'h0, 16'h038F, "R3 bit5 cleared");
      // R9 interrupt control
      op(0, 1, 4'h6, 16'h8002, "R9 config");
      rd(4'h6, 16'h8002, "R9 readback");
      op(0, 1, 4'h6, 16'h0007, "R9 relock");
      rd(4'h6, 16'h8002, "R9 frozen");
      op(1, 0, 4'h0, 0, "R5 tick 4->3");
      chk("R9 no early irq", irq, 0);
      op(1, 0, 4'h0, 0, "R9 tick 3->2");
      chk("R9 irq at interval", irq, 1);
      rd(4'h6, 16'hC002, "R9 status set");
      op(0, 1, 4'h6, 16'h4000, "R9 w1c");
      rd(4'h6, 16'h8002, "R9 status cleared");
      op(1, 0, 4'h0, 0, "R5 tick 2->1");
      op(1, 0, 4'h0, 0, "R5 expiry");
      chk("R5 expiry pulse", rst_req, 1);
      rd(4'h4, 16'h0002, "R5 cause timeout");
      op(0, 0, 4'h0, 0, "R5 single pulse");
      // R6 service sequences
      op(1, 0, 4'h0, 0, "R6 tick");
      op(1, 0, 4'h0, 0, "R6 tick");
      op(0, 1, 4'h6, 16'h4000, "R9 w1c");
      op(0, 1, 4'h2, 16'h5555, "R6 key1");
      op(0, 1, 4'h2, 16'hAAAA, "R6 key2");
      chk("R6 reload to full", m_cnt, 4);
      op(0, 1, 4'h2, 16'h5555, "R6 broken key1");
      op(0, 1, 4'h2, 16'h1234, "R6 broken stray");
      op(0, 1, 4'h2, 16'hAAAA, "R6 broken key2");
      op(1, 0, 4'h0, 0, "R6 tick");
      op(0, 1, 4'h2, 16'h5555, "R6 double key1a");
      op(0, 1, 4'h2, 16'h5555, "R6 double key1b");
      op(0, 1, 4'h2, 16'hAAAA, "R6 double key2");
      chk("R6 double 5555 reloads", m_cnt, 4);
      // R7 collision: count at 1, reload and expiring tick together
      op(1, 0, 4'h0, 0, "R7 tick");
      op(1, 0, 4'h0, 0, "R7 tick");
      op(0, 1, 4'h6, 16'h4000, "R9 w1c");
      op(1, 0, 4'h0, 0, "R7 tick to 1");
      op(0, 1, 4'h2, 16'h5555, "R7 arm");
      op(1, 1, 4'h2, 16'hAAAA, "R7 collision");
      chk("R7 no pulse on collision", rst_req, 0);
      op(1, 0, 4'h0, 0, "R7 after 1");
      op(1, 0, 4'h0, 0, "R7 after 2");
      op(1, 0, 4'h0, 0, "R7 after 3");
      chk("R7 no early expiry", rst_req, 0);
      op(1, 0, 4'h0, 0, "R7 after 4");
      chk("R7 full period then expiry", rst_req, 1);
      // R8 software reset
      op(0, 1, 4'h0, 16'h0310, "R8 sw reset");
      chk("R8 pulse", rst_req, 1);
      rd(4'h4, 16'h0001, "R8 cause software");
      rd(4'h0, 16'h038F, "R3 bit4 reads 0");
      // R11 misc
      op(0, 1, 4'h8, 16'h0000, "R11 clear pde");
      rd(4'h8, 16'h0000, "R11 pde cleared");
      op(0, 1, 4'h8, 16'h0001, "R11 set pde");
      rd(4'h8, 16'h0001, "R11 pde set");
      // random mix of ticks, keys, stray values, collisions and status clears (R5 R6 R7 R9)
      for (int i = 0; i < 400; i++) begin
         int unsigned k;
         k = $urandom % 9;
         case (k)
            0, 1, 2, 3: op(1, 0, 4'h0, 0, "R5 rnd tick");
            4: op(0, 1, 4'h2, 16'h5555, "R6 rnd key1");
            5: op(0, 1, 4'h2, 16'hAAAA, "R6 rnd key2");
            6: op(0, 1, 4'h2, 16'($urandom), "R6 rnd stray");
            7: op(1, 1, 4'h2, 16'hAAAA, "R7 rnd collision");
            default: op(0, 1, 4'h6, 16'h4000, "R9 rnd w1c");
         endcase
      end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule